// File: doc/BRIEF.md
# Hot-Key Detection Statistics Unit

This unit keeps popularity statistics for a key-value cache that lives in a switch data plane. It accepts at most one query per clock. Each query carries a key, a flag that says whether the key is already cached, and the cache slot number that holds it.

For a cached key, the unit adds one to that slot's hit counter. For an uncached key, it adds one to a frequency sketch with several rows and takes the smallest row value as the popularity estimate. An uncached key whose estimate reaches a programmable threshold is offered once to the control plane on a valid/ready report channel. A membership filter is written only when a report is accepted, and it keeps that key from being reported again.

The control plane reads any slot counter through a combinational read port. A single clear input wipes every statistic so that each measurement window starts from zero. The control plane weighs reported keys against slot counters when it decides what to insert or evict; that decision is made outside this unit.

Top module: `hotkey_stats`

## Requirements
- R1: A query with `q_cached`=1 adds one to the counter of slot `q_entry`, the counter stops at 65535 instead of wrapping, and the sketch is left untouched.
- R2: A query with `q_cached`=0 adds one, saturating at 65535, to one counter in each of 4 sketch rows. The counter for row r is column p[31:24], where p holds the low 32 bits of key*M_r. The multipliers are M_0=32'h9E3779B1, M_1=32'h85EBCA6B, M_2=32'hC2B2AE35 and M_3=32'h27D4EB2F.
- R3: The estimate of an uncached query is the minimum over the rows of the counters after this query's increment. A report is loaded when the estimate is at least the threshold, the key is absent from the filter, and no report is pending. The report carries the key and the estimate in `rpt_count` and appears the cycle after the query.
- R4: When a report is accepted (`rpt_valid` and `rpt_ready` both 1), filter bits q[31:22] are set, where q holds the low 32 bits of key*F_k, for F_0=32'h165667B1, F_1=32'hD3A2646D and F_2=32'hFD7046C5. A key whose three bits are all set is never reported.
- R5: A pending report keeps `rpt_valid`, `rpt_key` and `rpt_count` unchanged until it is accepted. A hot key met while a report is pending is not reported and is not written to the filter, so it can be reported on a later query.
- R6: `clr`=1 zeroes all sketch counters, filter bits and slot counters from the next cycle on. It drops any pending report, and the query presented in the same cycle has no effect.
- R7: `thr_we`=1 loads `thr_wdata` into the threshold, which applies from the next cycle on. The threshold is 8 after reset, and `clr` does not change it.
- R8: `rd_count` shows, in the same cycle, the current counter of slot `rd_entry`.
- R9: After reset, no report is pending and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | A query is present this cycle |
| q_key | input | 32 | Query key |
| q_cached | input | 1 | The key is held in the cache |
| q_entry | input | 6 | Cache slot of a cached key |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 16 | New threshold value |
| clr | input | 1 | Clear all statistics |
| rpt_valid | output | 1 | A hot-key report is pending |
| rpt_ready | input | 1 | The control plane accepts the report |
| rpt_key | output | 32 | Reported key |
| rpt_count | output | 16 | Estimate at the time of reporting |
| rd_entry | input | 6 | Slot counter to read |
| rd_count | output | 16 | Counter value of slot `rd_entry` |

## Verification
The delicate overlap is a report for key K being accepted in the same cycle that another query for K arrives. At that moment the filter bit write and the duplicate test meet. The bench repeats K while holding `rpt_ready` high and random, and it expects K to stay unreported for the rest of the window.

A second overlap is `clr` arriving together with a query and a pending acceptance. The bench injects such cycles during random traffic. In every cycle it compares the report channel and the slot read port against a behavioural model that uses queues of counters.

// File: rtl/hks_pkg.sv
package hks_pkg;
  localparam int KEY_W = 32;
  typedef logic [KEY_W-1:0] key_t;

  localparam int MAX_ROWS   = 4;
  localparam int MAX_HASHES = 3;

  localparam key_t SK_MULT [MAX_ROWS] = '{32'h9E3779B1, 32'h85EBCA6B,
                                          32'hC2B2AE35, 32'h27D4EB2F};
  localparam key_t BL_MULT [MAX_HASHES] = '{32'h165667B1, 32'hD3A2646D,
                                            32'hFD7046C5};

  function automatic key_t mix(key_t k, key_t m);
    return k * m;
  endfunction
endpackage

// File: rtl/hks_sketch.sv
module hks_sketch
  import hks_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 256,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  key_t             key,
  output logic [CNT_W-1:0] est
);
  localparam int IDX_W = $clog2(COLS);

  logic [CNT_W-1:0] row_nxt [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [CNT_W-1:0] cnt_q [COLS];
    key_t             prod;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cur;

    assign prod       = mix(key, SK_MULT[r]);
    assign idx        = prod[KEY_W-1 -: IDX_W];
    assign cur        = cnt_q[idx];
    assign row_nxt[r] = (cur == {CNT_W{1'b1}}) ? cur : cur + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < COLS; c++) cnt_q[c] <= '0;
      end else if (clr) begin
        for (int c = 0; c < COLS; c++) cnt_q[c] <= '0;
      end else if (upd) begin
        cnt_q[idx] <= row_nxt[r];
      end
    end
  end

  always_comb begin
    est = row_nxt[0];
    for (int r = 1; r < ROWS; r++) begin
      if (row_nxt[r] < est) est = row_nxt[r];
    end
  end
endmodule

// File: rtl/hks_bloom.sv
module hks_bloom
  import hks_pkg::*;
#(
  parameter int BITS   = 1024,
  parameter int HASHES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  key_t tst_key,
  output logic hit,
  input  logic set,
  input  key_t set_key
);
  localparam int IDX_W = $clog2(BITS);

  logic [BITS-1:0]   bits_q, bits_d;
  logic [IDX_W-1:0]  tidx [HASHES];
  logic [IDX_W-1:0]  sidx [HASHES];
  logic [HASHES-1:0] tbit;

  for (genvar k = 0; k < HASHES; k++) begin : g_hash
    key_t tp, sp;
    assign tp      = mix(tst_key, BL_MULT[k]);
    assign sp      = mix(set_key, BL_MULT[k]);
    assign tidx[k] = tp[KEY_W-1 -: IDX_W];
    assign sidx[k] = sp[KEY_W-1 -: IDX_W];
    assign tbit[k] = bits_q[tidx[k]];
  end

  assign hit = &tbit;

  always_comb begin
    bits_d = bits_q;
    if (clr) begin
      bits_d = '0;
    end else if (set) begin
      for (int k = 0; k < HASHES; k++) bits_d[sidx[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end
endmodule

// File: rtl/hks_entry_ctrs.sv
module hks_entry_ctrs #(
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 16,
  localparam int ID_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [ID_W-1:0]  inc_id,
  input  logic [ID_W-1:0]  rd_id,
  output logic [CNT_W-1:0] rd_cnt
);
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [CNT_W-1:0] cnt_d [ENTRIES];
  logic [CNT_W-1:0] sel;

  assign sel    = cnt_q[inc_id];
  assign rd_cnt = cnt_q[rd_id];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) cnt_d[e] = clr ? '0 : cnt_q[e];
    if (!clr && inc && (sel != {CNT_W{1'b1}})) cnt_d[inc_id] = sel + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) cnt_q[e] <= cnt_d[e];
    end
  end
endmodule

// File: rtl/hotkey_stats.sv
module hotkey_stats
  import hks_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int COLS        = 256,
  parameter int CNT_W       = 16,
  parameter int BLOOM_BITS  = 1024,
  parameter int HASHES      = 3,
  parameter int ENTRIES     = 64,
  parameter int THR_INIT    = 8,
  localparam int ID_W       = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_valid,
  input  logic [KEY_W-1:0] q_key,
  input  logic             q_cached,
  input  logic [ID_W-1:0]  q_entry,
  input  logic             thr_we,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             clr,
  output logic             rpt_valid,
  input  logic             rpt_ready,
  output logic [KEY_W-1:0] rpt_key,
  output logic [CNT_W-1:0] rpt_count,
  input  logic [ID_W-1:0]  rd_entry,
  output logic [CNT_W-1:0] rd_count
);
  logic             unc_upd, cac_upd;
  logic [CNT_W-1:0] est;
  logic             seen;
  logic             load, accept;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic             rv_q, rv_d;
  key_t             rk_q, rk_d;
  logic [CNT_W-1:0] rc_q, rc_d;

  assign unc_upd = q_valid && !q_cached && !clr;
  assign cac_upd = q_valid &&  q_cached && !clr;

  hks_sketch #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_sketch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(unc_upd), .key(q_key), .est(est)
  );

  hks_bloom #(.BITS(BLOOM_BITS), .HASHES(HASHES)) u_bloom (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tst_key(q_key), .hit(seen),
    .set(accept && !clr), .set_key(rk_q)
  );

  hks_entry_ctrs #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cac_upd), .inc_id(q_entry),
    .rd_id(rd_entry), .rd_cnt(rd_count)
  );

  assign accept = rv_q && rpt_ready;
  assign load   = unc_upd && (est >= thr_q) && !seen && !rv_q;

  always_comb begin
    thr_d = thr_we ? thr_wdata : thr_q;
    rv_d  = rv_q;
    rk_d  = rk_q;
    rc_d  = rc_q;
    if (clr) begin
      rv_d = 1'b0;
    end else if (load) begin
      rv_d = 1'b1;
      rk_d = q_key;
      rc_d = est;
    end else if (accept) begin
      rv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= CNT_W'(THR_INIT);
      rv_q  <= 1'b0;
      rk_q  <= '0;
      rc_q  <= '0;
    end else begin
      thr_q <= thr_d;
      rv_q  <= rv_d;
      rk_q  <= rk_d;
      rc_q  <= rc_d;
    end
  end

  assign rpt_valid = rv_q;
  assign rpt_key   = rk_q;
  assign rpt_count = rc_q;
endmodule

// File: rtl/hks_checker.sv
module hks_checker #(
  parameter int CNT_W = 16,
  parameter int ID_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_valid,
  input logic             q_cached,
  input logic [ID_W-1:0]  q_entry,
  input logic             clr,
  input logic             rpt_valid,
  input logic             rpt_ready,
  input logic [31:0]      rpt_key,
  input logic [CNT_W-1:0] rpt_count,
  input logic [ID_W-1:0]  rd_entry,
  input logic [CNT_W-1:0] rd_count,
  input logic [CNT_W-1:0] thr_q
);
  AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready && !clr |=> rpt_valid && $stable(rpt_key) && $stable(rpt_count)); // R5

  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rpt_valid); // R6

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_count == '0)); // R6

  AST_ENT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_cached && !clr && (q_entry == rd_entry) && (rd_count != {CNT_W{1'b1}})
    |=> (rd_entry != $past(rd_entry)) || (rd_count == CNT_W'($past(rd_count) + 1'b1))); // R1

  AST_ENT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_cached && !clr && (q_entry == rd_entry) && (rd_count == {CNT_W{1'b1}})
    |=> (rd_entry != $past(rd_entry)) || (rd_count == {CNT_W{1'b1}})); // R1

  AST_RPT_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> rpt_count >= $past(thr_q)); // R3

  AST_RPT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> $past(q_valid && !q_cached && !clr)); // R3
endmodule

bind hotkey_stats hks_checker #(.CNT_W(CNT_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/hotkey_stats_test.sv
module hotkey_stats_test;
  localparam int SAT = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        q_valid = 1'b0;
  logic [31:0] q_key = '0;
  logic        q_cached = 1'b0;
  logic [5:0]  q_entry = '0;
  logic        thr_we = 1'b0;
  logic [15:0] thr_wdata = '0;
  logic        clr = 1'b0;
  logic        rpt_ready = 1'b0;
  logic [5:0]  rd_entry = '0;
  logic        rpt_valid;
  logic [31:0] rpt_key;
  logic [15:0] rpt_count;
  logic [15:0] rd_count;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R9";
  bit done = 1'b0;

  hotkey_stats uut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_key(q_key), .q_cached(q_cached),
    .q_entry(q_entry), .thr_we(thr_we), .thr_wdata(thr_wdata), .clr(clr),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_key(rpt_key),
    .rpt_count(rpt_count), .rd_entry(rd_entry), .rd_count(rd_count)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int      m_sk [4][256];
  bit      m_bl [1024];
  int      m_ent [64];
  int      m_thr;
  bit      m_rv;
  int      m_rk;
  int      m_rc;
  int      sk_m [4] = '{32'h9E3779B1, 32'h85EBCA6B, 32'hC2B2AE35, 32'h27D4EB2F};
  int      bl_m [3] = '{32'h165667B1, 32'hD3A2646D, 32'hFD7046C5};

  function automatic int top_bits(logic [31:0] k, logic [31:0] m, int n);
    logic [31:0] p;
    p = k * m;
    return int'(p >> (32 - n));
  endfunction

  task automatic model_reset();
    foreach (m_sk[r, c]) m_sk[r][c] = 0;
    foreach (m_bl[i]) m_bl[i] = 1'b0;
    foreach (m_ent[e]) m_ent[e] = 0;
    m_rv = 1'b0;
  endtask

  initial begin
    model_reset();
    m_thr = 8;
    m_rk = 0;
    m_rc = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      bit acc, hot, inb;
      int est;
      acc = m_rv && rpt_ready;
      hot = 1'b0;
      est = 0;
      if (clr) begin
        model_reset();
      end else begin
        if (q_valid && q_cached && m_ent[q_entry] < SAT) m_ent[q_entry]++;
        if (q_valid && !q_cached) begin
          est = SAT;
          for (int r = 0; r < 4; r++) begin
            int ix;
            ix = top_bits(q_key, sk_m[r], 8);
            if (m_sk[r][ix] < SAT) m_sk[r][ix]++;
            if (m_sk[r][ix] < est) est = m_sk[r][ix];
          end
          inb = 1'b1;
          for (int k = 0; k < 3; k++) if (!m_bl[top_bits(q_key, bl_m[k], 10)]) inb = 1'b0;
          hot = (est >= m_thr) && !inb;
        end
        if (acc) for (int k = 0; k < 3; k++) m_bl[top_bits(m_rk, bl_m[k], 10)] = 1'b1;
        if (hot && !m_rv) begin
          m_rv = 1'b1;
          m_rk = q_key;
          m_rc = est;
        end else if (acc) begin
          m_rv = 1'b0;
        end
      end
      if (thr_we) m_thr = thr_wdata;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rpt_valid !== m_rv || (m_rv && (rpt_key !== m_rk[31:0] || rpt_count !== m_rc[15:0]))
          || rd_count !== m_ent[rd_entry][15:0]) begin
        miscompares++;
        $display("FAIL %s t=%0t: rpt v/k/c=%0b/%h/%0d rd=%0d expected %0b/%h/%0d rd=%0d",
                 tag, $time, rpt_valid, rpt_key, rpt_count, rd_count,
                 m_rv, m_rk, m_rc, m_ent[rd_entry]);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, logic [31:0] k, bit c, int e);
    @(posedge clk);
    #1;
    q_valid = v; q_key = k; q_cached = c; q_entry = 6'(e);
    thr_we = 1'b0; clr = 1'b0;
  endtask

  task automatic idle();
    cyc(1'b0, 32'h0, 1'b0, 0);
  endtask

  task automatic set_thr(int t);
    @(posedge clk);
    #1;
    q_valid = 1'b0; clr = 1'b0;
    thr_we = 1'b1; thr_wdata = 16'(t);
  endtask

  task automatic do_clr(bit v, logic [31:0] k);
    @(posedge clk);
    #1;
    q_valid = v; q_key = k; q_cached = 1'b0; thr_we = 1'b0; clr = 1'b1;
  endtask

  initial begin
    #(190000 * 10);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    tag = "R9";
    check(rpt_valid == 1'b0, "R9", rpt_valid, 0);
    check(rd_count == 0, "R9", rd_count, 0);

    // R8 and R1: slot counters and read port
    tag = "R8";
    for (int i = 0; i < 10; i++) cyc(1'b1, 32'(i * 7), 1'b1, i % 4);
    idle();
    for (int e = 0; e < 4; e++) begin
      rd_entry = 6'(e);
      @(negedge clk);
      check(rd_count == ((e < 2) ? 3 : 2), "R8", rd_count, (e < 2) ? 3 : 2);
    end

    // R7: threshold 5, R3 report on fifth query, R5 hold without ready
    tag = "R7";
    set_thr(5);
    tag = "R3";
    rpt_ready = 1'b0;
    for (int i = 0; i < 5; i++) cyc(1'b1, 32'hA1A1_0001, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_valid && rpt_key == 32'hA1A1_0001, "R3", rpt_valid, 1);
    check(rpt_count == 5, "R3", rpt_count, 5);
    tag = "R5";
    for (int i = 0; i < 6; i++) cyc(1'b1, 32'hB2B2_0002, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_key == 32'hA1A1_0001, "R5", rpt_key, 32'hA1A1_0001);
    rpt_ready = 1'b1;
    idle();
    rpt_ready = 1'b0;
    // R4: the accepted key is not reported again, the blocked one is
    tag = "R4";
    for (int i = 0; i < 3; i++) cyc(1'b1, 32'hA1A1_0001, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_valid == 1'b0, "R4", rpt_valid, 0);
    tag = "R5";
    cyc(1'b1, 32'hB2B2_0002, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_valid && rpt_key == 32'hB2B2_0002, "R5", rpt_key, 32'hB2B2_0002);

    // accept and same-key query in one cycle
    tag = "R4";
    rpt_ready = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b1, 32'hB2B2_0002, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_valid == 1'b0, "R4", rpt_valid, 0);

    // R6: clear with a pending report and a simultaneous query
    tag = "R6";
    rpt_ready = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 32'hC3C3_0003, 1'b0, 0);
    do_clr(1'b1, 32'hC3C3_0003);
    idle();
    @(negedge clk);
    check(rpt_valid == 1'b0, "R6", rpt_valid, 0);
    rd_entry = 6'd0;
    @(negedge clk);
    check(rd_count == 0, "R6", rd_count, 0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 32'hA1A1_0001, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_valid && rpt_count == 5, "R6", rpt_count, 5);

    // R2 R3 R7: random traffic with collisions, thresholds and clears
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      #1;
      q_valid   = ($urandom_range(0, 9) != 0);
      q_key     = 32'($urandom_range(0, 40)) * 32'h0101_0101;
      q_cached  = ($urandom_range(0, 3) == 0);
      q_entry   = 6'($urandom_range(0, 63));
      rd_entry  = 6'($urandom_range(0, 63));
      rpt_ready = ($urandom_range(0, 2) == 0);
      thr_we    = ($urandom_range(0, 199) == 0);
      thr_wdata = 16'($urandom_range(2, 30));
      clr       = ($urandom_range(0, 999) == 0);
    end
    idle();
    rpt_ready = 1'b1;
    idle();

    // R1 and R2: saturation
    tag = "R1";
    do_clr(1'b0, 32'h0);
    rd_entry = 6'd3;
    for (int i = 0; i < SAT + 5; i++) cyc(1'b1, 32'h0, 1'b1, 3);
    idle();
    @(negedge clk);
    check(rd_count == SAT, "R1", rd_count, SAT);
    tag = "R2";
    rpt_ready = 1'b0;
    set_thr(SAT);
    for (int i = 0; i < SAT + 5; i++) cyc(1'b1, 32'h5A5A_1234, 1'b0, 0);
    idle();
    @(negedge clk);
    check(rpt_valid && rpt_count == SAT, "R2", rpt_count, SAT);
    check(rd_count == SAT, "R1", rd_count, SAT);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule